// File: doc/BRIEF.md
# Transmit Port Selection Controller

This block decides when a device sharing a parallel transmit bus owns that bus, and writes the bus words into its transmit FIFO or transmit input register while it does. On every rising edge of the sampling clock it reads three active-low controls: a chip enable (`ce_n`), a transmit reset line (`txrst_n`) and a transmit enable (`txen_n`). From these it derives a match condition, a reset-match condition and a selected state. The selected state produces a registered write strobe with the captured word. The block also drives registered output enables for the FIFO full and empty flags, so that an unmatched device leaves those shared flag lines to its neighbours.

A static mode input `fifo_en` picks the sampling clock: the transmit clock when the FIFO is in use, and the reference clock when it is bypassed. It is a strap, and it changes only while reset is held. In bypass mode the flags always show an empty FIFO.

The controller is a four-state machine. **IDLE** means no match. **MATCH** means the device is addressed but not writing. **SELECTED** means a word is written every clock. **RST_MATCH** means a transmit reset sequence is in progress. The transitions, in priority order, are:
- Any state goes to IDLE when `ce_n` is sampled high.
- Any state goes to RST_MATCH when `ce_n` and `txrst_n` are both sampled low.
- SELECTED goes to MATCH when `txen_n` is sampled high, and otherwise stays in SELECTED.
- IDLE, MATCH and RST_MATCH go to SELECTED on a falling `txen_n`, meaning the previous sample was high and the current sample is low.
- In every other case, IDLE, MATCH and RST_MATCH go to MATCH.

Top module: `tx_port_select`

## Requirements
- R1: While `rst_n` is low, `wr_en`, `flag_oe`, `flag_full` and `flag_empty` are 0. The state is IDLE and the previous `txen_n` sample is taken as high.
- R2: An edge that samples `ce_n`=0 and `txrst_n`=1 makes `flag_oe` 1 in the cycle after that edge.
- R3: An edge that samples `ce_n`=1 makes both `flag_oe` and `wr_en` 0 in the cycle after, even if the port was selected.
- R4: An edge that samples `ce_n`=0 and `txrst_n`=0 keeps `flag_oe` at 1 and forces `wr_en` to 0. Selection and the reset sequence never coexist.
- R5: An edge that samples `ce_n`=0, `txrst_n`=1 and `txen_n`=0 selects the port, provided the previous edge sampled `txen_n`=1. This holds whether `ce_n` went low at an earlier edge or at this same edge. After that edge `wr_en`=1 and `wr_data` holds the `txdata` word sampled at that edge.
- R6: While the port stays selected, every edge captures the current `txdata` into `wr_data`, with `wr_en` held at 1.
- R7: A selected port that samples `txen_n`=1 drops `wr_en` to 0 in the next cycle and stays matched (`flag_oe`=1).
- R8: If `txen_n` is already low when the match forms, or stays low after a reset sequence, no selection occurs. `wr_en` stays 0 until `txen_n` goes high and then low again.
- R9: With `fifo_en`=1 all sampling happens on `tx_clk`. With `fifo_en`=0 all sampling happens on `ref_clk`, and `tx_clk` edges have no effect.
- R10: While `flag_oe`=1, `flag_full` and `flag_empty` follow `fifo_full` and `fifo_empty` when `fifo_en`=1. When `fifo_en`=0 they read 0 and 1. While `flag_oe`=0 both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock, used when the FIFO is enabled |
| ref_clk | input | 1 | Reference clock, used when the FIFO is bypassed |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = FIFO used, 0 = FIFO bypassed; static strap |
| ce_n | input | 1 | Active-low chip enable |
| txrst_n | input | 1 | Active-low transmit reset line; high is the select qualifier |
| txen_n | input | 1 | Active-low transmit enable |
| txdata | input | DATA_W | Word on the shared transmit bus |
| fifo_full | input | 1 | Full status from the transmit FIFO |
| fifo_empty | input | 1 | Empty status from the transmit FIFO |
| wr_en | output | 1 | Write strobe toward the FIFO or input register |
| wr_data | output | DATA_W | Word captured for the write |
| flag_oe | output | 1 | Output enable for the shared flag drivers |
| flag_full | output | 1 | Full flag value for the pad driver |
| flag_empty | output | 1 | Empty flag value for the pad driver |

## Verification
The hardest situation to reach is the one where a match forms while `txen_n` is already low. The port must then refuse selection until `txen_n` rises and falls again. The bench reaches it by lowering `txen_n` while `ce_n` is still high, and by leaving `txen_n` low across a reset sequence. It then checks that no write strobe appears until `txen_n` toggles. Clock-source selection is checked in bypass mode by asserting the chip enable just before a `tx_clk` edge that falls between two `ref_clk` edges, and confirming that nothing changes until the next `ref_clk` edge.

// File: rtl/tpsc_pkg.sv
package tpsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_MATCH     = 2'd1,
        ST_SELECTED  = 2'd2,
        ST_RST_MATCH = 2'd3
    } tpsc_state_e;
endpackage

// File: rtl/tpsc_clk_sel.sv
// Static clock source pick; fifo_en is a strap changed only in reset.
module tpsc_clk_sel (
    input  logic tx_clk,
    input  logic ref_clk,
    input  logic fifo_en,
    output logic smp_clk
);
    assign smp_clk = fifo_en ? tx_clk : ref_clk;
endmodule

// File: rtl/tpsc_txen_edge.sv
// Holds the previous txen_n sample and flags a high-to-low change.
module tpsc_txen_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic txen_n,
    output logic txen_fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= txen_n;
    end

    assign txen_fall = prev_q & ~txen_n;
endmodule

// File: rtl/tpsc_fsm.sv
module tpsc_fsm
    import tpsc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              txrst_n,
    input  logic              txen_n,
    input  logic              txen_fall,
    input  logic [DATA_W-1:0] txdata,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              match_oe
);
    tpsc_state_e state_q, state_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (ce_n) begin
            state_d = ST_IDLE;
        end else if (!txrst_n) begin
            state_d = ST_RST_MATCH;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_MATCH, ST_RST_MATCH:
                    state_d = txen_fall ? ST_SELECTED : ST_MATCH;
                ST_SELECTED:
                    state_d = txen_n ? ST_MATCH : ST_SELECTED;
                default:
                    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_data  <= '0;
            match_oe <= 1'b0;
        end else begin
            wr_en    <= (state_d == ST_SELECTED);
            match_oe <= (state_d != ST_IDLE);
            if (state_d == ST_SELECTED) wr_data <= txdata;
        end
    end
endmodule

// File: rtl/tpsc_flag_drv.sv
module tpsc_flag_drv (
    input  logic fifo_en,
    input  logic oe,
    input  logic fifo_full,
    input  logic fifo_empty,
    output logic flag_full,
    output logic flag_empty
);
    assign flag_full  = oe & fifo_en & fifo_full;
    assign flag_empty = oe & (fifo_en ? fifo_empty : 1'b1);
endmodule

// File: rtl/tx_port_select.sv
module tx_port_select #(
    parameter int DATA_W = 8
) (
    input  logic              tx_clk,
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              ce_n,
    input  logic              txrst_n,
    input  logic              txen_n,
    input  logic [DATA_W-1:0] txdata,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              flag_oe,
    output logic              flag_full,
    output logic              flag_empty
);
    logic smp_clk;
    logic txen_fall;

    tpsc_clk_sel u_clk (
        .tx_clk  (tx_clk),
        .ref_clk (ref_clk),
        .fifo_en (fifo_en),
        .smp_clk (smp_clk)
    );

    tpsc_txen_edge u_edge (
        .clk       (smp_clk),
        .rst_n     (rst_n),
        .txen_n    (txen_n),
        .txen_fall (txen_fall)
    );

    tpsc_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (smp_clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .txrst_n   (txrst_n),
        .txen_n    (txen_n),
        .txen_fall (txen_fall),
        .txdata    (txdata),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .match_oe  (flag_oe)
    );

    tpsc_flag_drv u_flag (
        .fifo_en    (fifo_en),
        .oe         (flag_oe),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .flag_full  (flag_full),
        .flag_empty (flag_empty)
    );
endmodule

// File: rtl/tx_port_select_chk.sv
module tx_port_select_chk (
    input logic tx_clk,
    input logic ref_clk,
    input logic rst_n,
    input logic fifo_en,
    input logic ce_n,
    input logic txrst_n,
    input logic txen_n,
    input logic wr_en,
    input logic flag_oe,
    input logic flag_full,
    input logic flag_empty
);
    logic ck;
    assign ck = fifo_en ? tx_clk : ref_clk;

    // R3
    deselect_drop_chk: assert property (@(posedge ck) disable iff (!rst_n)
        ce_n |=> (!flag_oe && !wr_en));

    // R2
    match_set_chk: assert property (@(posedge ck) disable iff (!rst_n)
        (!ce_n && txrst_n) |=> flag_oe);

    // R4
    rst_excl_chk: assert property (@(posedge ck) disable iff (!rst_n)
        (!ce_n && !txrst_n) |=> (flag_oe && !wr_en));

    // R6
    sel_hold_chk: assert property (@(posedge ck) disable iff (!rst_n)
        (wr_en && !ce_n && txrst_n && !txen_n) |=> wr_en);

    // R7
    sel_exit_chk: assert property (@(posedge ck) disable iff (!rst_n)
        txen_n |=> !wr_en);

    // R10
    bypass_empty_chk: assert property (@(posedge ck) disable iff (!rst_n)
        (flag_oe && !fifo_en) |-> (flag_empty && !flag_full));

    // R10
    hiz_quiet_chk: assert property (@(posedge ck) disable iff (!rst_n)
        !flag_oe |-> (!flag_full && !flag_empty));
endmodule

bind tx_port_select tx_port_select_chk u_chk (
    .tx_clk     (tx_clk),
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .ce_n       (ce_n),
    .txrst_n    (txrst_n),
    .txen_n     (txen_n),
    .wr_en      (wr_en),
    .flag_oe    (flag_oe),
    .flag_full  (flag_full),
    .flag_empty (flag_empty)
);

// File: tb/tb_tx_port_select.sv
`timescale 1ns/1ps
module tb_tx_port_select;
    localparam int DW = 8;

    logic tx_clk = 1'b0, ref_clk = 1'b0;
    logic rst_n = 1'b0, fifo_en = 1'b1;
    logic ce_n = 1'b1, txrst_n = 1'b1, txen_n = 1'b1;
    logic [DW-1:0] txdata = '0;
    logic fifo_full = 1'b0, fifo_empty = 1'b1;
    logic wr_en, flag_oe, flag_full, flag_empty;
    logic [DW-1:0] wr_data;
    int n_chk = 0, n_bad = 0;

    always #2 tx_clk = ~tx_clk;   // 250 MHz
    always #4 ref_clk = ~ref_clk; // edges fall between tx_clk edges

    tx_port_select #(.DATA_W(DW)) dut (
        .tx_clk(tx_clk), .ref_clk(ref_clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .ce_n(ce_n), .txrst_n(txrst_n), .txen_n(txen_n), .txdata(txdata),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .wr_en(wr_en), .wr_data(wr_data), .flag_oe(flag_oe),
        .flag_full(flag_full), .flag_empty(flag_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        if (fifo_en) @(posedge tx_clk); else @(posedge ref_clk);
        #1;
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; ce_n = 1'b1; txrst_n = 1'b1; txen_n = 1'b1;
        fifo_en = mode;
        #9;
        chk("R1 wr_en", wr_en, 0);
        chk("R1 flag_oe", flag_oe, 0);
        chk("R1 flags", {flag_full, flag_empty}, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_match_select();
        fifo_full = 1'b1; fifo_empty = 1'b0;
        ce_n = 1'b0; tick();
        chk("R2 flag_oe", flag_oe, 1);
        chk("R10 fifo flags", {flag_full, flag_empty}, 2'b10);
        chk("R2 no write", wr_en, 0);
        txen_n = 1'b0; txdata = 8'hA5; tick();
        chk("R5 wr_en", wr_en, 1);
        chk("R5 wr_data", wr_data, 8'hA5);
        txdata = 8'h3C; tick();
        chk("R6 wr_en", wr_en, 1);
        chk("R6 wr_data", wr_data, 8'h3C);
        txen_n = 1'b1; tick();
        chk("R7 wr_en", wr_en, 0);
        chk("R7 flag_oe", flag_oe, 1);
        ce_n = 1'b1; tick();
        chk("R3 flag_oe", flag_oe, 0);
        chk("R10 hiz flags", {flag_full, flag_empty}, 0);
    endtask

    task automatic t_same_edge();
        ce_n = 1'b0; txen_n = 1'b0; txdata = 8'h5E; tick();
        chk("R5 same-edge wr_en", wr_en, 1);
        chk("R5 same-edge data", wr_data, 8'h5E);
        ce_n = 1'b1; tick();
        chk("R3 drop while selected", wr_en, 0);
        chk("R3 oe off", flag_oe, 0);
        txen_n = 1'b1; tick();
    endtask

    task automatic t_no_fall();
        txen_n = 1'b0; tick();
        ce_n = 1'b0; tick();
        chk("R8 no select", wr_en, 0);
        chk("R8 matched", flag_oe, 1);
        tick();
        chk("R8 still no select", wr_en, 0);
        txen_n = 1'b1; tick();
        txen_n = 1'b0; txdata = 8'h77; tick();
        chk("R8 select after toggle", wr_en, 1);
        chk("R8 data", wr_data, 8'h77);
    endtask

    task automatic t_rst_seq();
        txrst_n = 1'b0; tick();
        chk("R4 wr_en", wr_en, 0);
        chk("R4 flag_oe", flag_oe, 1);
        txrst_n = 1'b1; tick();
        chk("R8 after reset seq", wr_en, 0);
        chk("R2 rematch", flag_oe, 1);
        ce_n = 1'b1; txen_n = 1'b1; tick();
    endtask

    task automatic t_bypass();
        do_reset(1'b0);
        fifo_full = 1'b1; fifo_empty = 1'b0;
        ce_n = 1'b0;
        @(posedge tx_clk); #1;
        chk("R9 tx_clk ignored", flag_oe, 0);
        tick();
        chk("R9 ref_clk samples", flag_oe, 1);
        chk("R10 bypass flags", {flag_full, flag_empty}, 2'b01);
        txen_n = 1'b0; txdata = 8'hC3; tick();
        chk("R9 bypass write", wr_en, 1);
        chk("R9 bypass data", wr_data, 8'hC3);
        ce_n = 1'b1; txen_n = 1'b1; tick();
        chk("R3 bypass drop", flag_oe, 0);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        t_match_select();
        t_same_edge();
        t_no_fall();
        t_rst_seq();
        t_bypass();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule